// File: doc/BRIEF.md
# Shifted-Operand Recomputing Adder Checker

This block adds two unsigned operands and checks its own answer without a second adder. It runs a single ripple-carry adder twice. The first pass adds the operands as given. The second pass adds both operands moved up by `SHIFT` bit positions, with zeros entering at the bottom. The second result is moved back down by `SHIFT` and compared with the first. If the two differ, the result is flagged as untrustworthy.

A permanent fault sits in one fixed bit-slice. In the two passes it therefore damages different bit weights of the true sum, so it cannot corrupt both results in the same way. The adder is wider than the operands by `SHIFT` bits, plus a carry, so the shifted pass keeps every high bit.

Operands enter on a valid/ready handshake. Ready is high only while the block is idle, and that is the only back-pressure it applies: a source must hold its request until ready. The result side is a plain one-cycle done strobe with no back-pressure. A fault-injection input can force the sum output of any one adder bit-slice to a fixed level during both passes, so that detection can be exercised.

Top module: `reso_add_checker`

## Requirements
- R1: Synchronous active-high reset returns the block to idle. While reset is applied and in the cycle after it, `out_valid` and `out_err` are 0 and `in_ready` is 1.
- R2: A pair of operands is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when no check is running.
- R3: For the three cycles after the accepting edge, `in_ready` is 0. Operands or requests presented during those cycles are ignored: they do not change the result under way, and they do not produce an extra result.
- R4: `out_valid` is high in the fourth cycle after the accepting cycle: two compute cycles, one compare cycle, then the registered output. It stays high for exactly one cycle.
- R5: With fault injection off, `out_sum` equals A+B as a `W+1`-bit value, with the carry in bit `W`, and `out_err` is 0.
- R6: The second pass adds `A<<SHIFT` and `B<<SHIFT` on a `W+SHIFT`-bit adder with a carry out, so no operand bit is lost. All-ones operands give no error and the correct sum.
- R7: `out_err` is 1 exactly when the first-pass result (`W+SHIFT+1` bits) differs from the second-pass result shifted right by `SHIFT`.
- R8: A stuck sum bit in any single slice that corrupts `out_sum` always sets `out_err`. When `out_err` is 0, `out_sum` is A+B.
- R9: While `flt_en` is 1, the sum output of slice `flt_slice` is forced to `flt_val` in both passes. Slice indices run from 0 (least significant) to `W+SHIFT-1`.
- R10: `out_sum` and `out_err` change only in cycles where `out_valid` is high, or on reset. Otherwise they hold their last values.
- R11: In the cycle where `out_valid` is high, `in_ready` is also 1, so a new pair can be accepted in the same cycle as the previous result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle; an offered pair is taken |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| flt_en | input | 1 | Enable stuck-at injection |
| flt_slice | input | $clog2(W+SHIFT) | Index of the faulted adder slice |
| flt_val | input | 1 | Level the faulted slice sum is forced to |
| out_valid | output | 1 | One-cycle done strobe |
| out_sum | output | W+1 | First-pass sum including carry |
| out_err | output | 1 | Passes disagreed for this result |

## Verification
Two functions can fall in the same cycle: delivery of a finished result on `out_valid`, and acceptance of the next operand pair. The bench provokes this by holding `in_valid` high with fresh operands through the whole check, so the handshake completes in the same cycle as the done strobe. It then requires both flags high in that cycle and a correct first result. It also requires the second result to arrive exactly four cycles later as its own single-cycle strobe, with the new operands' sum. Outside this overlap, an exhaustive sweep covers all operand pairs of a 4-bit, shift-2 build, both with the fault injection off and with every slice stuck at 0 and at 1.

// File: rtl/reso_pkg.sv
package reso_pkg;
  // Phase of one check: idle, unshifted pass, shifted pass, compare.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BASE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_CHECK = 2'd3
  } phase_t;
endpackage

// File: rtl/reso_slice.sv
// One full-adder bit-slice whose sum output can be forced to a stuck level.
module reso_slice (
  input  logic a,
  input  logic b,
  input  logic ci,
  input  logic stuck_on,
  input  logic stuck_val,
  output logic s,
  output logic co
);
  logic half;
  always_comb begin
    half = a ^ b;
    s    = stuck_on ? stuck_val : (half ^ ci);
    co   = (a & b) | (ci & half);
  end
endmodule

// File: rtl/reso_ripple.sv
// Ripple-carry adder built from injectable slices; result carries the top carry.
module reso_ripple #(
  parameter int unsigned DW  = 10,
  parameter int unsigned SLW = 4
) (
  input  logic [DW-1:0]  x,
  input  logic [DW-1:0]  y,
  input  logic           flt_en,
  input  logic [SLW-1:0] flt_slice,
  input  logic           flt_val,
  output logic [DW:0]    sum
);
  logic [DW:0]   carry;
  logic [DW-1:0] bits;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_slice
    logic hit;
    assign hit = flt_en && (flt_slice == SLW'(i));
    reso_slice u_slice (
      .a        (x[i]),
      .b        (y[i]),
      .ci       (carry[i]),
      .stuck_on (hit),
      .stuck_val(flt_val),
      .s        (bits[i]),
      .co       (carry[i+1])
    );
  end

  assign sum = {carry[DW], bits};
endmodule

// File: rtl/reso_operand_sel.sv
// Presents the operands to the adder either as-is or moved up with zero fill.
module reso_operand_sel #(
  parameter int unsigned W     = 8,
  parameter int unsigned SHIFT = 2,
  localparam int unsigned DW   = W + SHIFT
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          shifted,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y
);
  logic [DW-1:0] a_lo, b_lo, a_hi, b_hi;

  always_comb begin
    a_lo = {{SHIFT{1'b0}}, a};
    b_lo = {{SHIFT{1'b0}}, b};
    a_hi = {a, {SHIFT{1'b0}}};
    b_hi = {b, {SHIFT{1'b0}}};
    x    = shifted ? a_hi : a_lo;
    y    = shifted ? b_hi : b_lo;
  end
endmodule

// File: rtl/reso_align_cmp.sv
// Moves the shifted-pass result back down and compares it with the plain pass.
module reso_align_cmp #(
  parameter int unsigned DW    = 10,
  parameter int unsigned SHIFT = 2
) (
  input  logic [DW:0] plain_res,
  input  logic [DW:0] moved_res,
  output logic        mismatch
);
  logic [DW:0] realigned;
  always_comb begin
    realigned = moved_res >> SHIFT;
    mismatch  = (plain_res != realigned);
  end
endmodule

// File: rtl/reso_add_checker.sv
// Time-redundant adder: one adder used twice, second time on shifted operands.
module reso_add_checker
  import reso_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned SHIFT  = 2,
  localparam int unsigned DW    = W + SHIFT,
  localparam int unsigned SLW   = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic           flt_en,
  input  logic [SLW-1:0] flt_slice,
  input  logic           flt_val,
  output logic           out_valid,
  output logic [W:0]     out_sum,
  output logic           out_err
);
  phase_t        phase;
  logic [W-1:0]  a_q, b_q;
  logic [DW:0]   plain_q, moved_q;
  logic [DW-1:0] add_x, add_y;
  logic [DW:0]   add_res;
  logic          mismatch;
  logic          fire;

  assign in_ready = (phase == ST_IDLE);
  assign fire     = in_valid && in_ready;

  reso_operand_sel #(.W(W), .SHIFT(SHIFT)) u_sel (
    .a      (a_q),
    .b      (b_q),
    .shifted(phase == ST_SHIFT),
    .x      (add_x),
    .y      (add_y)
  );

  reso_ripple #(.DW(DW), .SLW(SLW)) u_add (
    .x        (add_x),
    .y        (add_y),
    .flt_en   (flt_en),
    .flt_slice(flt_slice),
    .flt_val  (flt_val),
    .sum      (add_res)
  );

  reso_align_cmp #(.DW(DW), .SHIFT(SHIFT)) u_cmp (
    .plain_res(plain_q),
    .moved_res(moved_q),
    .mismatch (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_IDLE;
      a_q       <= '0;
      b_q       <= '0;
      plain_q   <= '0;
      moved_q   <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      unique case (phase)
        ST_IDLE: begin
          if (fire) begin
            a_q   <= in_a;
            b_q   <= in_b;
            phase <= ST_BASE;
          end
        end
        ST_BASE: begin
          plain_q <= add_res;
          phase   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          moved_q <= add_res;
          phase   <= ST_CHECK;
        end
        ST_CHECK: begin
          out_valid <= 1'b1;
          out_sum   <= plain_q[W:0];
          out_err   <= mismatch;
          phase     <= ST_IDLE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reso_add_checker_sva.sv
// Property checker attached to the adder checker.
module reso_add_checker_sva #(
  parameter int unsigned W      = 8,
  parameter int unsigned SHIFT  = 2,
  localparam int unsigned DW    = W + SHIFT,
  localparam int unsigned SLW   = $clog2(DW)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           flt_en,
  input logic [SLW-1:0] flt_slice,
  input logic           flt_val,
  input logic           out_valid,
  input logic [W:0]     out_sum,
  input logic           out_err
);
  logic             live;
  logic             fire;
  logic [W-1:0]     snap_a, snap_b;
  logic [SLW+1:0]   flt_q;
  logic             flt_any;
  logic             flt_moved;
  logic [W:0]       snap_sum;

  assign fire     = in_valid && in_ready;
  assign snap_sum = (W+1)'(snap_a) + (W+1)'(snap_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      live      <= 1'b0;
      snap_a    <= '0;
      snap_b    <= '0;
      flt_q     <= '0;
      flt_any   <= 1'b0;
      flt_moved <= 1'b0;
    end else begin
      live <= 1'b1;
      if (fire) begin
        snap_a    <= in_a;
        snap_b    <= in_b;
        flt_q     <= {flt_en, flt_slice, flt_val};
        flt_any   <= flt_en;
        flt_moved <= 1'b0;
      end else if (!in_ready) begin
        flt_any   <= flt_any | flt_en;
        flt_moved <= flt_moved | ({flt_en, flt_slice, flt_val} != flt_q);
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && in_ready));  // R1

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst || !live)
    fire |=> !in_ready ##1 !in_ready ##1 !in_ready);  // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst || !live)
    fire |=> !out_valid ##1 !out_valid ##1 !out_valid ##1 out_valid);  // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst || !live)
    out_valid |=> !out_valid);  // R4

  AST_CLEAN_SUM: assert property (@(posedge clk) disable iff (rst || !live)
    (out_valid && !flt_any && !flt_moved) |-> (!out_err && out_sum == snap_sum));  // R5

  AST_NO_SILENT_CORRUPT: assert property (@(posedge clk) disable iff (rst || !live)
    (out_valid && !flt_moved && !out_err) |-> (out_sum == snap_sum));  // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst || !live)
    !out_valid |-> ($stable(out_err) && $stable(out_sum)));  // R10

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst || !live)
    out_valid |-> in_ready);  // R11
endmodule

bind reso_add_checker reso_add_checker_sva #(.W(W), .SHIFT(SHIFT)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_a     (in_a),
  .in_b     (in_b),
  .flt_en   (flt_en),
  .flt_slice(flt_slice),
  .flt_val  (flt_val),
  .out_valid(out_valid),
  .out_sum  (out_sum),
  .out_err  (out_err)
);

// File: tb/reso_add_checker_test.sv
module reso_add_checker_test;
  localparam int W     = 4;
  localparam int SHIFT = 2;
  localparam int DW    = W + SHIFT;
  localparam int SLW   = $clog2(DW);
  localparam int WDOG  = 120000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_a = '0;
  logic [W-1:0]   in_b = '0;
  logic           flt_en = 1'b0;
  logic [SLW-1:0] flt_slice = '0;
  logic           flt_val = 1'b0;
  logic           in_ready, out_valid, out_err;
  logic [W:0]     out_sum;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  reso_add_checker #(.W(W), .SHIFT(SHIFT)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .flt_en(flt_en), .flt_slice(flt_slice),
    .flt_val(flt_val), .out_valid(out_valid), .out_sum(out_sum), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", WDOG, 0);
    report();
  end

  // Expected result from the requirement text: both passes, stuck bit, realign.
  task automatic model(input int a, input int b, input bit en, input int sl, input bit v,
                       output int sum, output int err);
    logic [DW:0] r1, r2;
    r1 = (DW+1)'(a) + (DW+1)'(b);
    r2 = ((DW+1)'(a) << SHIFT) + ((DW+1)'(b) << SHIFT);
    if (en) begin
      r1[sl] = v;
      r2[sl] = v;
    end
    err = (r1 != (r2 >> SHIFT)) ? 1 : 0;
    sum = int'(r1[W:0]);
  endtask

  // Called at a negedge; returns at the negedge where out_valid is seen.
  task automatic run_op(input int a, input int b, output int sum, output int err,
                        output int lat, output bit busy_ok);
    busy_ok = 1'b1;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_a = W'(a);
    in_b = W'(b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 12) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    sum = int'(out_sum);
    err = int'(out_err);
  endtask

  initial begin
    int s, e, lat, es, ee;
    bit bo;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_err == 1'b0, "R1 err in reset", int'(out_err), 0);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready when idle", int'(in_ready), 1);

    // Exhaustive fault-free sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(a, b, s, e, lat, bo);
        chk(s == a + b, "R5 sum", s, a + b);
        chk(e == 0, "R5 R6 no error without fault", e, 0);
        chk(lat == 4, "R4 latency", lat, 4);
        chk(bo, "R3 ready low while busy", int'(bo), 1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 single-cycle done", int'(out_valid), 0);
      end
    end

    // All-ones boundary for wide shifted path
    run_op((1 << W) - 1, (1 << W) - 1, s, e, lat, bo);
    chk(s == 2 * ((1 << W) - 1), "R6 all-ones sum", s, 2 * ((1 << W) - 1));
    chk(e == 0, "R6 all-ones no error", e, 0);
    @(negedge clk);

    // Exhaustive single-slice stuck-at sweep
    for (int sl = 0; sl < DW; sl++) begin
      for (int v = 0; v < 2; v++) begin
        flt_en = 1'b1;
        flt_slice = SLW'(sl);
        flt_val = v[0];
        for (int a = 0; a < (1 << W); a++) begin
          for (int b = 0; b < (1 << W); b++) begin
            run_op(a, b, s, e, lat, bo);
            model(a, b, 1'b1, sl, v[0], es, ee);
            chk(s == es, "R9 forced slice sum", s, es);
            chk(e == ee, "R7 error matches realigned compare", e, ee);
            if (e == 0) chk(s == a + b, "R8 unflagged result correct", s, a + b);
            @(negedge clk);
          end
        end
      end
    end

    // Hold: flagged result stays while idle, then a clean run clears it
    flt_en = 1'b1; flt_slice = SLW'(0); flt_val = 1'b1;
    run_op(2, 2, s, e, lat, bo);
    chk(e == 1, "R8 stuck-1 on bit0 of even sum flagged", e, 1);
    flt_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(out_err == 1'b1, "R10 err held while idle", int'(out_err), 1);
    chk(out_sum == 5'd5, "R10 sum held while idle", int'(out_sum), 5);
    run_op(2, 2, s, e, lat, bo);
    chk(e == 0, "R10 err updates at next done", e, 0);
    @(negedge clk);

    // Ignored requests while busy
    in_valid = 1'b1; in_a = W'(5); in_b = W'(6);
    @(posedge clk); @(negedge clk);
    in_a = W'(15); in_b = W'(15);
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R3 first result on time", int'(out_valid), 1);
    chk(int'(out_sum) == 11, "R3 busy-time operands ignored", int'(out_sum), 11);
    begin
      int extra = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      chk(extra == 0, "R3 no result from ignored request", extra, 0);
    end

    // Back-to-back: done and next accept in the same cycle
    in_valid = 1'b1; in_a = W'(3); in_b = W'(4);
    @(posedge clk); @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R11 done strobe", int'(out_valid), 1);
    chk(in_ready == 1'b1, "R11 ready in done cycle", int'(in_ready), 1);
    chk(int'(out_sum) == 7, "R11 first result", int'(out_sum), 7);
    in_a = W'(9); in_b = W'(7);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 accepted in done cycle", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R4 done not stretched", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R11 second result on time", int'(out_valid), 1);
    chk(int'(out_sum) == 16, "R11 second sum", int'(out_sum), 16);
    chk(out_err == 1'b0, "R11 second no error", int'(out_err), 0);

    // Reset during a check
    @(negedge clk);
    in_valid = 1'b1; in_a = W'(1); in_b = W'(1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R1 reset aborts check", int'(in_ready), 1);
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      chk(seen == 0, "R1 no result after reset", seen, 0);
    end
    chk(out_err == 1'b0, "R1 err cleared", int'(out_err), 0);

    report();
  end
endmodule